// File: doc/BRIEF.md
# Lockstep Multi-Lane Serial Master

This block is a serial master that runs several data lanes at once. All lanes share one serial clock and one active-low select line. Each lane has its own output data pin, its own input data pin, a 16-bit word to send and a 16-bit word to collect. A single start pulse captures every lane's outgoing word. The block then sends all the words together, most significant bit first. After one spare clock period it collects one word from each lane, again most significant bit first. When the transaction ends, the collected words appear on a parallel bus and a one-cycle done pulse is raised.

The serial clock is derived from the system clock. One bit period lasts a parameterised number of system clocks, split into equal low and high halves. With a 200 MHz system clock, the default of 20 clocks per bit gives a 10 MHz serial clock. A value of 18 gives about 11.1 MHz. Configurations with fewer lanes can use shorter periods. The lane count runs from 1 to 8.

Top module: `mlane_spi_master`

## Requirements
- R1: After reset, and whenever no transaction is running, `cs_n` is 1, `sclk` is 0, every `mosi` pin is 0, and `busy` and `done` are 0.
- R2: A `start` pulse while idle latches `tx_words`. From the next cycle, `busy` is 1 and `cs_n` is 0 for exactly (2·WIDTH+3)·P system clocks, where P is the bit period.
- R3: While `busy` is 1, `start` and changes on `tx_words` have no effect. The words sent are the ones latched at launch, the transaction length is unchanged, and no new transaction begins after it ends.
- R4: P equals DIV when DIV is even and at least 4. An odd DIV is rounded up to the next even number, and anything below 4 becomes 4. Every `sclk` pulse is high for P/2 clocks, and `sclk` stays low for P/2 clocks between consecutive pulses.
- R5: Lane k's word sits at bits [k·WIDTH+WIDTH-1 : k·WIDTH] of `tx_words`. On the first WIDTH falling edges of `sclk`, that word appears on `mosi[k]`, bit WIDTH-1 first. `mosi` changes one system clock after a falling edge, so it never changes on the edge itself.
- R6: The period after the write phase is a filler. `sclk` pulses once and `mosi` is 0 at its falling edge. A transaction has 2·WIDTH+1 `sclk` pulses in total.
- R7: In each of the WIDTH periods after the filler, every `miso[k]` is sampled one system clock before `sclk` falls. The samples are packed bit WIDTH-1 first into lane k's slice of `rx_words`, which uses the same layout as `tx_words`.
- R8: `cs_n` falls P+P/2 system clocks before the first `sclk` rise. It rises P system clocks after the last `sclk` fall, counting the cycle of that fall.
- R9: `done` is a single-cycle pulse in the first cycle with `busy` at 0. `rx_words` holds the new result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, taken only while idle |
| tx_words | input | LANES*WIDTH | Outgoing words, one slice per lane |
| miso | input | LANES | Serial input per lane |
| sclk | output | 1 | Shared serial clock, idles low |
| cs_n | output | 1 | Shared active-low select |
| mosi | output | LANES | Serial output per lane |
| busy | output | 1 | High for the whole transaction |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rx_words | output | LANES*WIDTH | Collected words, one slice per lane |

## Verification
The bench runs a three-lane build with an odd divider, so the even rounding of the bit period is exercised. A bench-side slave decodes every lane on each transaction. The patterns are all zeros, all ones, alternating bits that differ between neighbouring lanes, a single set bit walked through every position with a different offset per lane, and hashed words. The flat patterns expose stuck pins and a missing filler. The walking bit shows bit order and an off-by-one shift on both phases. Per-lane offsets catch lanes that are swapped or merged. Some runs pulse `start` and flip `tx_words` mid-transaction, which shows that a second request is refused.

// File: rtl/mlane_spi_master.sv
module mlane_spi_master #(
  parameter int LANES = 6,
  parameter int WIDTH = 16,
  parameter int DIV   = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [LANES*WIDTH-1:0] tx_words,
  input  logic [LANES-1:0]       miso,
  output logic                   sclk,
  output logic                   cs_n,
  output logic [LANES-1:0]       mosi,
  output logic                   busy,
  output logic                   done,
  output logic [LANES*WIDTH-1:0] rx_words
);
  localparam int PER   = (DIV < 4) ? 4 : DIV + (DIV % 2);
  localparam int HALF  = PER / 2;
  localparam int NSLOT = 2 * WIDTH + 3;
  localparam int CW    = $clog2(PER);
  localparam int SW    = $clog2(NSLOT);

  logic [CW-1:0]          cnt;
  logic [SW-1:0]          slot;
  logic [LANES*WIDTH-1:0] tx_sh;
  logic [LANES*WIDTH-1:0] rx_sh;
  logic [LANES-1:0]       mosi_q;

  wire last_cnt  = cnt == CW'(PER - 1);
  wire wr_slot   = slot >= SW'(1) && slot <= SW'(WIDTH);
  wire fill_slot = slot == SW'(WIDTH + 1);
  wire rd_slot   = slot >= SW'(WIDTH + 2) && slot <= SW'(2 * WIDTH + 1);

  assign sclk = busy && (wr_slot || fill_slot || rd_slot) && cnt >= CW'(HALF);
  assign cs_n = !busy;
  assign mosi = mosi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      slot     <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      mosi_q   <= '0;
      rx_words <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          cnt   <= '0;
          slot  <= '0;
          tx_sh <= tx_words;
        end
      end else begin
        cnt <= last_cnt ? '0 : cnt + CW'(1);
        if (last_cnt) begin
          if (slot == SW'(NSLOT - 1)) begin
            busy     <= 1'b0;
            done     <= 1'b1;
            rx_words <= rx_sh;
          end else begin
            slot <= slot + SW'(1);
          end
        end
        if (cnt == '0 && wr_slot) begin
          for (int l = 0; l < LANES; l++) begin
            mosi_q[l]                 <= tx_sh[l*WIDTH + WIDTH-1];
            tx_sh[l*WIDTH +: WIDTH]   <= tx_sh[l*WIDTH +: WIDTH] << 1;
          end
        end
        if (cnt == '0 && fill_slot) mosi_q <= '0;
        if (cnt == CW'(PER - 2) && rd_slot) begin
          for (int l = 0; l < LANES; l++)
            rx_sh[l*WIDTH +: WIDTH] <= {rx_sh[l*WIDTH +: WIDTH-1], miso[l]};
        end
      end
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sclk && mosi == '0));
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_high_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |=> sclk);
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> $stable(mosi));
  p_done_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_mlane_spi_master.sv
module sim_mlane_spi_master;
  localparam int L = 3, W = 16, DIV = 5, PER = 6, HALF = 3, NSL = 2 * W + 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [L*W-1:0] tx_words = '0;
  logic [L-1:0] miso;
  wire sclk, cs_n, busy, done;
  wire [L-1:0] mosi;
  wire [L*W-1:0] rx_words;

  mlane_spi_master #(.LANES(L), .WIDTH(W), .DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .tx_words(tx_words), .miso(miso),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done), .rx_words(rx_words));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int falls = 0, rises = 0, lead = 0, tail = 0, blen = 0, hi = 0, lo = 0, dones = 0;
  bit sp = 1'b0, cp = 1'b1, seen = 1'b0, tim_bad = 1'b0, fill_bad = 1'b0, done_bad = 1'b0;
  logic [W-1:0] cap [L];
  logic [W-1:0] resp [L];
  logic [W-1:0] sent [L];
  logic [L*W-1:0] rx_at_done = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always_comb
    for (int l = 0; l < L; l++)
      miso[l] = (falls >= W + 1 && falls <= 2 * W) ? resp[l][2 * W - falls] : 1'b0;

  always @(negedge clk) begin
    if (!cs_n && cp) begin
      falls = 0; rises = 0; lead = 0; tail = 0; blen = 0; hi = 0; lo = 0;
      seen = 0; tim_bad = 0; fill_bad = 0;
      for (int l = 0; l < L; l++) cap[l] = '0;
    end
    if (!cs_n) begin
      blen++;
      if (sclk && !sp) begin
        rises++;
        if (seen && lo != HALF) tim_bad = 1;
        seen = 1; hi = 1;
      end else if (!sclk && sp) begin
        falls++;
        if (hi != HALF) tim_bad = 1;
        lo = 1;
        if (falls <= W) for (int l = 0; l < L; l++) cap[l] = {cap[l][W-2:0], mosi[l]};
        if (falls == W + 1 && mosi != '0) fill_bad = 1;
      end else if (sclk) hi++;
      else lo++;
      if (!seen) lead++;
      if (falls == 2 * W + 1) tail++;
    end
    if (cs_n && sclk) tim_bad = 1;
    if (done) begin
      dones++;
      rx_at_done = rx_words;
      if (busy) done_bad = 1;
    end
    sp = sclk; cp = cs_n;
  end

  function automatic logic [W-1:0] pat(int t, int l);
    if (t == 0) return '0;
    if (t == 1) return '1;
    if (t == 2) return (l % 2) ? 16'hAAAA : 16'h5555;
    if (t < 19) return W'(1) << ((t - 3 + l) % W);
    return W'((t * 40503 + l * 9973 + 12345) ^ (t << l));
  endfunction

  task automatic run(int t, bit poke);
    int n;
    for (int l = 0; l < L; l++) begin
      sent[l] = pat(t, l);
      tx_words[l*W +: W] = sent[l];
      resp[l] = pat((t + 7) % 24, l) ^ W'(l * 16'h1111);
    end
    dones = 0; done_bad = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      tx_words = ~tx_words;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (!done && n < NSL * PER * 2) begin
      @(negedge clk);
      n++;
    end
    repeat (PER * 2) @(negedge clk);
    for (int l = 0; l < L; l++) begin
      chk(cap[l] == sent[l], "R5", $sformatf("mosi lane %0d pattern %0d", l, t), cap[l], sent[l]);
      chk(rx_at_done[l*W +: W] == resp[l], "R7", $sformatf("rx lane %0d pattern %0d", l, t),
          rx_at_done[l*W +: W], resp[l]);
    end
    chk(!tim_bad, "R4", "sclk half periods", tim_bad, 0);
    chk(rises == 2 * W + 1, "R6", "sclk pulse count", rises, 2 * W + 1);
    chk(!fill_bad, "R6", "mosi idle in filler", fill_bad, 0);
    chk(lead == PER + HALF, "R8", "select lead", lead, PER + HALF);
    chk(tail == PER, "R8", "select tail", tail, PER);
    chk(blen == NSL * PER, "R2", "busy length", blen, NSL * PER);
    chk(dones == 1 && !done_bad, "R9", "done pulse", dones, 1);
    if (poke) chk(cs_n && !busy, "R3", "no relaunch after busy start", busy, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < L; l++) begin resp[l] = '0; sent[l] = '0; cap[l] = '0; end
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !done && mosi == '0, "R1", "reset state",
        {cs_n, sclk, busy, done}, 4'b1000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && mosi == '0, "R1", "idle after reset",
        {cs_n, sclk, busy}, 3'b100);
    for (int t = 0; t < 24; t++) run(t, (t % 5) == 4);
    chk(cs_n && !sclk && mosi == '0, "R1", "idle at end", {cs_n, sclk}, 2'b10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule